// File: doc/BRIEF.md
# Chained Counter Pair with Watchdog Reset

This block holds two equal-width up-counters that advance on a shared count enable. With the chaining bit clear, each counter runs on its own. Each counter has a sticky wrap flag that software clears. With the chaining bit set, the pair acts as one counter of twice the width. Counter A is the low half. Counter B is the high half, and it advances only in the cycle in which A rolls over.

The watchdog bit ties the wrap flag of counter B to a system reset request. The request is a pulse of fixed length. When the pulse ends, the flag and the watchdog bit are cleared. Software keeps the system alive by writing a fresh start value into the counters before B wraps. The watchdog works with B alone or with the chained pair. While the watchdog bit is set, software can neither clear it nor clear B's flag.

Top module: `cascade_wdt_top`

## Requirements
- R1: After rst_ni is released, both counters read 0, both wrap flags are 0, both mode bits are 0 and sys_rst_o is 0.
- R2: With chaining off, each counter that is not being loaded adds 1 modulo 2^CNT_W on every clock with cnt_en_i high.
- R3: With cnt_en_i low and no load, both counters keep their values.
- R4: A counter's wrap flag is set at the clock edge on which that counter goes from all ones to zero. The flag then stays set until it is cleared.
- R5: Writing the configuration with bit 6 set turns chaining on. Counter B then advances only on a clock on which counter A wraps.
- R6: With chaining on, {b_cnt_o, a_cnt_o} counts modulo 2^(2*CNT_W), and B's flag is set when the combined value wraps.
- R7: A software load takes priority over counting. The counter takes the written value on that edge and does not wrap on it.
- R8: A flag clear input clears the matching flag. For counter B this holds only while the watchdog bit is 0. A wrap on the same edge wins over the clear.
- R9: Writing the configuration with bit 5 set turns the watchdog on. Once B's flag is set with the watchdog on, sys_rst_o goes high one clock later and stays high for exactly RST_LEN clocks.
- R10: On the edge that ends the reset pulse, B's wrap flag and the watchdog bit both return to 0.
- R11: While the watchdog bit is 1, a configuration write cannot clear it, and b_clr_i has no effect on B's flag.
- R12: If software reloads the counters often enough that B never wraps, sys_rst_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_en_i | input | 1 | Count enable |
| a_wr_i | input | 1 | Load strobe for counter A |
| a_wdata_i | input | CNT_W | Load value for counter A |
| b_wr_i | input | 1 | Load strobe for counter B |
| b_wdata_i | input | CNT_W | Load value for counter B |
| a_clr_i | input | 1 | Clear counter A wrap flag |
| b_clr_i | input | 1 | Clear counter B wrap flag |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration data: bit 6 chaining, bit 5 watchdog |
| a_cnt_o | output | CNT_W | Counter A value |
| b_cnt_o | output | CNT_W | Counter B value |
| a_ovf_o | output | 1 | Counter A wrap flag |
| b_ovf_o | output | 1 | Counter B wrap flag |
| chain_o | output | 1 | Chaining bit |
| wdog_o | output | 1 | Watchdog bit |
| sys_rst_o | output | 1 | Reset request pulse |

## Verification
A wrong carry path shows at the ports within one clock. In chained mode, the high counter moves on a clock when the low counter does not wrap, and the combined value is off from the first step. A fault in the pulse stage shows as a reset pulse that is one clock too short or too long, or that starts too late. It can also show as a flag or watchdog bit that is still set after the pulse. Either case is visible within RST_LEN+2 clocks of the wrap. Sweeps over every counter value at a 4-bit width reach each wrap within a few hundred clocks.

// File: rtl/cascade_wdt_pkg.sv
package cascade_wdt_pkg;
  localparam int unsigned CFG_W     = 8;
  localparam int unsigned CHAIN_BIT = 6;
  localparam int unsigned WDOG_BIT  = 5;
endpackage

// File: rtl/cwt_counter.sv
module cwt_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o,
  output logic         flag_o
);
  logic [W-1:0] cnt_q;
  logic         flag_q;

  assign wrap_o = inc_i && !ld_i && (cnt_q == {W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (ld_i)       cnt_q <= ld_val_i;
      else if (inc_i) cnt_q <= cnt_q + 1'b1;
      if (wrap_o)     flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !ld_i) |=> $stable(cnt_q));
  assert_flag_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  assert_load_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (cnt_q == $past(ld_val_i)));
endmodule

// File: rtl/cwt_pulse.sv
module cwt_pulse #(
  parameter int unsigned LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o,
  output logic done_o
);
  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic          act_q;
  logic [CW-1:0] cnt_q;

  assign done_o = act_q && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (!act_q) begin
      if (trig_i) begin
        act_q <= 1'b1;
        cnt_q <= '0;
      end
    end else if (done_o) begin
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pulse_o = act_q;

  assert_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> (cnt_q == '0));
endmodule

// File: rtl/cascade_wdt_top.sv
module cascade_wdt_top
  import cascade_wdt_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned RST_LEN = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             a_wr_i,
  input  logic [CNT_W-1:0] a_wdata_i,
  input  logic             b_wr_i,
  input  logic [CNT_W-1:0] b_wdata_i,
  input  logic             a_clr_i,
  input  logic             b_clr_i,
  input  logic             cfg_wr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CNT_W-1:0] a_cnt_o,
  output logic [CNT_W-1:0] b_cnt_o,
  output logic             a_ovf_o,
  output logic             b_ovf_o,
  output logic             chain_o,
  output logic             wdog_o,
  output logic             sys_rst_o
);
  logic chain_q, wdog_q;
  logic a_wrap, b_wrap, b_inc, b_clr;
  logic pulse, pulse_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= 1'b0;
      wdog_q  <= 1'b0;
    end else begin
      if (cfg_wr_i) chain_q <= cfg_wdata_i[CHAIN_BIT];
      // watchdog bit: set-only from software, cleared by pulse end
      if (pulse_done)    wdog_q <= 1'b0;
      else if (cfg_wr_i) wdog_q <= wdog_q | cfg_wdata_i[WDOG_BIT];
    end
  end

  assign b_inc = chain_q ? (cnt_en_i && a_wrap) : cnt_en_i;
  assign b_clr = (b_clr_i && !wdog_q) || pulse_done;

  cwt_counter #(.W(CNT_W)) u_cnt_a (
    .clk_i, .rst_ni,
    .inc_i(cnt_en_i), .ld_i(a_wr_i), .ld_val_i(a_wdata_i), .clr_i(a_clr_i),
    .cnt_o(a_cnt_o), .wrap_o(a_wrap), .flag_o(a_ovf_o)
  );

  cwt_counter #(.W(CNT_W)) u_cnt_b (
    .clk_i, .rst_ni,
    .inc_i(b_inc), .ld_i(b_wr_i), .ld_val_i(b_wdata_i), .clr_i(b_clr),
    .cnt_o(b_cnt_o), .wrap_o(b_wrap), .flag_o(b_ovf_o)
  );

  cwt_pulse #(.LEN(RST_LEN)) u_pulse (
    .clk_i, .rst_ni,
    .trig_i(wdog_q && b_ovf_o),
    .pulse_o(pulse), .done_o(pulse_done)
  );

  assign chain_o   = chain_q;
  assign wdog_o    = wdog_q;
  assign sys_rst_o = pulse;

  assert_chain_carry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain_q && !b_wr_i && (a_cnt_o != {CNT_W{1'b1}})) |=> $stable(b_cnt_o));
  assert_rst_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> ($past(wdog_q) && $past(b_ovf_o)));
  assert_rst_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> (!wdog_q && !b_wrap |-> !b_ovf_o));
  assert_wdog_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdog_q && !sys_rst_o) |=> wdog_q);
  assert_flag_locked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdog_q && b_ovf_o && !sys_rst_o) |=> b_ovf_o);
endmodule

// File: tb/cascade_wdt_top_tb_top.sv
module cascade_wdt_top_tb_top;
  localparam int W  = 4;
  localparam int RL = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cnt_en_i = 1'b0;
  logic         a_wr_i = 1'b0, b_wr_i = 1'b0, a_clr_i = 1'b0, b_clr_i = 1'b0;
  logic [W-1:0] a_wdata_i = '0, b_wdata_i = '0;
  logic         cfg_wr_i = 1'b0;
  logic [7:0]   cfg_wdata_i = '0;
  logic [W-1:0] a_cnt_o, b_cnt_o;
  logic         a_ovf_o, b_ovf_o, chain_o, wdog_o, sys_rst_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc_cnt = 0;

  cascade_wdt_top #(.CNT_W(W), .RST_LEN(RL)) dut_i (
    .clk_i, .rst_ni, .cnt_en_i,
    .a_wr_i, .a_wdata_i, .b_wr_i, .b_wdata_i,
    .a_clr_i, .b_clr_i, .cfg_wr_i, .cfg_wdata_i,
    .a_cnt_o, .b_cnt_o, .a_ovf_o, .b_ovf_o,
    .chain_o, .wdog_o, .sys_rst_o
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle_inputs();
    a_wr_i = 0; b_wr_i = 0; a_clr_i = 0; b_clr_i = 0; cfg_wr_i = 0;
  endtask

  always @(posedge clk_i) begin
    cyc_cnt++;
    if (cyc_cnt > 20000) begin
      n_fail++;
      $display("FAIL watchdog timeout");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int exp_v;
    int b0;
    cyc(); cyc();
    rst_ni = 1'b1;
    cyc();
    // R1 reset state
    chk(a_cnt_o == 0 && b_cnt_o == 0, "R1 counts", {a_cnt_o, b_cnt_o}, 0);
    chk(!a_ovf_o && !b_ovf_o, "R1 flags", {a_ovf_o, b_ovf_o}, 0);
    chk(!chain_o && !wdog_o && !sys_rst_o, "R1 mode", {chain_o, wdog_o, sys_rst_o}, 0);

    // independent mode sweep
    a_wr_i = 1; a_wdata_i = 5; b_wr_i = 1; b_wdata_i = 9;
    cyc(); idle_inputs();
    cnt_en_i = 1;
    for (int k = 1; k <= 20; k++) begin
      cyc();
      chk(a_cnt_o == (5 + k) % 16, "R2 a count", a_cnt_o, (5 + k) % 16);
      chk(b_cnt_o == (9 + k) % 16, "R2 b count", b_cnt_o, (9 + k) % 16);
      chk(a_ovf_o == (k >= 11), "R4 a flag", a_ovf_o, k >= 11);
      chk(b_ovf_o == (k >= 7), "R4 b flag", b_ovf_o, k >= 7);
    end
    // R7 load wins over increment
    a_wr_i = 1; a_wdata_i = 3;
    cyc(); idle_inputs();
    chk(a_cnt_o == 3, "R7 load priority", a_cnt_o, 3);
    // R3 hold
    cnt_en_i = 0;
    exp_v = b_cnt_o;
    for (int k = 0; k < 5; k++) begin
      cyc();
      chk(a_cnt_o == 3 && b_cnt_o == exp_v, "R3 hold", {a_cnt_o, b_cnt_o}, (3 << 4) | exp_v);
    end
    // R8 flag clear
    a_clr_i = 1; b_clr_i = 1;
    cyc(); idle_inputs();
    chk(!a_ovf_o && !b_ovf_o, "R8 clear", {a_ovf_o, b_ovf_o}, 0);
    // R8 set wins over clear
    a_wr_i = 1; a_wdata_i = 4'hF;
    cyc(); idle_inputs();
    cnt_en_i = 1; a_clr_i = 1;
    cyc(); idle_inputs(); cnt_en_i = 0;
    chk(a_ovf_o == 1, "R8 wrap beats clear", a_ovf_o, 1);

    // chained sweep
    cfg_wr_i = 1; cfg_wdata_i = 8'h40;
    a_wr_i = 1; a_wdata_i = 0; b_wr_i = 1; b_wdata_i = 0; a_clr_i = 1; b_clr_i = 1;
    cyc(); idle_inputs();
    chk(chain_o == 1 && wdog_o == 0, "R5 chain bit", {chain_o, wdog_o}, 2);
    cnt_en_i = 1;
    for (int k = 1; k <= 300; k++) begin
      cyc();
      exp_v = k % 256;
      chk({b_cnt_o, a_cnt_o} == exp_v[7:0], "R6 chained value", {b_cnt_o, a_cnt_o}, exp_v);
      chk(b_ovf_o == (k >= 256), "R6 chained flag", b_ovf_o, k >= 256);
      chk(!sys_rst_o, "R9 no reset without watchdog", sys_rst_o, 0);
    end

    // watchdog on chained pair
    cnt_en_i = 0;
    cfg_wr_i = 1; cfg_wdata_i = 8'h60;
    a_wr_i = 1; a_wdata_i = 4'hD; b_wr_i = 1; b_wdata_i = 4'hF; a_clr_i = 1; b_clr_i = 1;
    cyc(); idle_inputs();
    chk(wdog_o == 1 && b_ovf_o == 0, "R9 watchdog armed", {wdog_o, b_ovf_o}, 2);
    cnt_en_i = 1;
    for (int k = 1; k <= 10; k++) begin
      if (k == 1) begin cfg_wr_i = 1; cfg_wdata_i = 8'h40; end
      if (k == 5) b_clr_i = 1;
      cyc(); idle_inputs();
      exp_v = (8'hFD + k) % 256;
      chk({b_cnt_o, a_cnt_o} == exp_v[7:0], "R6 chained value wd", {b_cnt_o, a_cnt_o}, exp_v);
      chk(sys_rst_o == (k >= 4 && k <= 3 + RL), "R9 pulse timing", sys_rst_o, k >= 4 && k <= 3 + RL);
      chk(b_ovf_o == (k >= 3 && k <= 3 + RL), "R10 flag", b_ovf_o, k >= 3 && k <= 3 + RL);
      chk(wdog_o == (k <= 3 + RL), "R11 R10 watchdog bit", wdog_o, k <= 3 + RL);
    end

    // single-timer watchdog, serviced then left to expire
    cnt_en_i = 0;
    cfg_wr_i = 1; cfg_wdata_i = 8'h20;
    a_wr_i = 1; a_wdata_i = 0; b_wr_i = 1; b_wdata_i = 4'hA; a_clr_i = 1; b_clr_i = 1;
    cyc(); idle_inputs();
    chk(chain_o == 0 && wdog_o == 1, "R9 single mode", {chain_o, wdog_o}, 1);
    cnt_en_i = 1;
    for (int i = 0; i < 30; i++) begin
      if (i % 4 == 0) begin b_wr_i = 1; b_wdata_i = 4'hA; end
      cyc(); idle_inputs();
      chk(!sys_rst_o && !b_ovf_o, "R12 serviced", {sys_rst_o, b_ovf_o}, 0);
    end
    b0 = 4'hB;
    chk(b_cnt_o == b0, "R2 b after service", b_cnt_o, b0);
    for (int k = 1; k <= 11; k++) begin
      cyc();
      exp_v = 16 - b0;
      chk(b_cnt_o == (b0 + k) % 16, "R2 b single", b_cnt_o, (b0 + k) % 16);
      chk(b_ovf_o == (k >= exp_v && k <= exp_v + RL), "R10 single flag", b_ovf_o,
          k >= exp_v && k <= exp_v + RL);
      chk(sys_rst_o == (k >= exp_v + 1 && k <= exp_v + RL), "R9 single pulse", sys_rst_o,
          k >= exp_v + 1 && k <= exp_v + RL);
    end
    chk(!wdog_o, "R10 watchdog cleared", wdog_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule